// File: doc/BRIEF.md
# Address Bus Memory Subsystem

This block is the memory side of a small 8-bit processor that uses a 16-bit address space. The lower half of the space (0x0000 to 0x7FFF) is read-only storage holding a boot image; the upper half (0x8000 to 0xFFFF) is writable storage. The top address bit alone picks the half. The two halves are backed by arrays smaller than 32K each, so each region repeats its array, indexed by the low address bits.

The address comes from a dedicated 16-bit address bus, separate from the 8-bit data bus. Either the program counter or the address register drives that bus, selected by two drive enables. In manual mode a switch address replaces the bus, and a switch byte replaces the data bus as the write source. The block also resolves the shared data bus. It can place the addressed memory byte on it. It can place one half of the address bus on it. An outside unit may drive it as well. Clashes on either bus are flagged.

The data bus is a shared wire set, not a stream, so every pin is a plain level with no valid/ready handshake and no back-pressure. A strobe acts in the cycle it is high. Read paths are combinational, and a write lands at the next rising clock edge.

Top module: `abus_mem_subsys`

## Requirements
- R1: An address with bit 15 low reads the read-only array at index addr[ROM_AW-1:0]. An address with bit 15 high reads the writable array at index addr[RAM_AW-1:0]. Bit 15 is never part of either index.
- R2: A write strobe while bit 15 of the memory address is low changes nothing: every later read returns the same bytes as before.
- R3: A write strobe while bit 15 is high stores the write byte at the addressed location at the next rising edge, and mem_data shows it from then on.
- R4: The address bus carries pc_addr when pc_drive is high. It carries ar_addr when only ar_drive is high, and 0x0000 when neither is high. When both are high the program counter wins.
- R5: With run_mode high the memory address is the address bus and the write byte is the resolved data bus. With run_mode low they are sw_addr and sw_data.
- R6: mem_out places mem_data on dbus and raises dbus_oe.
- R7: addr_out places one byte of the address bus (not the switch address) on dbus and raises dbus_oe. hi_sel=1 selects bits 15:8 and hi_sel=0 selects bits 7:0.
- R8: manual_drive is high only when run_mode is low, mem_wr is high and bit 15 of the address is high. It is low at all other times.
- R9: abus_clash is high exactly when pc_drive and ar_drive are both high. dbus_clash is high exactly when two or more of mem_out, addr_out and ext_drive are high.
- R10: Read-only index 0 holds JMP_OP, index 1 holds 0x00 and index 2 holds 0x80, forming a little-endian jump to 0x8000. Every index i of 3 or more holds (i*37+11) mod 256.
- R11: The data bus priority is mem_out, then addr_out, then ext_drive. When only ext_drive is high, dbus equals ext_data and dbus_oe stays low. When no driver is high, dbus is 0x00 and dbus_oe is low.
- R12: Reset clears every writable location to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_addr | input | 16 | Program counter value |
| ar_addr | input | 16 | Address register value |
| pc_drive | input | 1 | Program counter drives the address bus |
| ar_drive | input | 1 | Address register drives the address bus |
| run_mode | input | 1 | 1: address bus and data bus are the sources; 0: switches are the sources |
| sw_addr | input | 16 | Manual switch address |
| sw_data | input | 8 | Manual switch byte |
| mem_wr | input | 1 | Write strobe |
| mem_out | input | 1 | Drive the addressed byte onto the data bus |
| addr_out | input | 1 | Drive one address bus byte onto the data bus |
| hi_sel | input | 1 | Byte select for addr_out (1 = high) |
| ext_drive | input | 1 | Another unit drives the data bus |
| ext_data | input | 8 | Byte from that unit |
| dbus | output | 8 | Resolved data bus value |
| dbus_oe | output | 1 | This block drives the data bus |
| mem_addr | output | 16 | Address presented to the arrays |
| mem_data | output | 8 | Byte stored at mem_addr |
| manual_drive | output | 1 | The switch byte path drives the memory data lines |
| abus_clash | output | 1 | Both address bus drivers enabled |
| dbus_clash | output | 1 | More than one data bus driver enabled |

## Verification
The bench builds the block with RAM_AW=6, ROM_AW=4 and JMP_OP=0xC3. The writable region therefore repeats every 64 bytes and the read-only region every 16 bytes, so random addresses often alias. Aliasing checks that bit 15 and the upper index bits never reach the arrays. The small writable array also means random writes often revisit the same locations, so stored values are read back many times. A non-default jump opcode confirms that the boot word comes from the parameter.

// File: rtl/abus_mem_pkg.sv
package abus_mem_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {SRC_NONE, SRC_MEM, SRC_ADDR, SRC_EXT} dbus_src_e;

  // Boot image: little-endian jump to the base of the writable region, then a filler pattern.
  function automatic logic [DATA_W-1:0] rom_byte(input int unsigned idx,
                                                 input logic [DATA_W-1:0] jmp_op);
    case (idx)
      0: return jmp_op;
      1: return 8'h00;
      2: return 8'h80;
      default: return 8'((idx * 37 + 11) % 256);
    endcase
  endfunction
endpackage

// File: rtl/abus_addr_path.sv
module abus_addr_path
  import abus_mem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] pc_addr,
  input  logic [ADDR_W-1:0] ar_addr,
  input  logic              pc_drive,
  input  logic              ar_drive,
  input  logic              run_mode,
  input  logic [ADDR_W-1:0] sw_addr,
  output logic [ADDR_W-1:0] abus,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              ram_sel,
  output logic              abus_clash
);
  always_comb begin
    if (pc_drive)      abus = pc_addr;
    else if (ar_drive) abus = ar_addr;
    else               abus = '0;
  end

  always_comb begin
    mem_addr   = run_mode ? abus : sw_addr;
    ram_sel    = mem_addr[ADDR_W-1];
    abus_clash = pc_drive & ar_drive;
  end

  // R4: with no driver the run-mode address is zero
  a_r4_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    run_mode && !pc_drive && !ar_drive |-> mem_addr == '0);
  // R5: manual mode ignores the address bus entirely
  a_r5_manual_src: assert property (@(posedge clk) disable iff (!rst_n)
    !run_mode |-> mem_addr == sw_addr);
endmodule

// File: rtl/abus_rom.sv
module abus_rom
  import abus_mem_pkg::*;
#(
  parameter int ROM_AW = 4,
  parameter logic [DATA_W-1:0] JMP_OP = 8'h60
) (
  input  logic [ROM_AW-1:0] idx,
  output logic [DATA_W-1:0] rdata
);
  localparam int ROM_DEPTH = 1 << ROM_AW;

  logic [DATA_W-1:0] rom_mem [ROM_DEPTH];

  for (genvar i = 0; i < ROM_DEPTH; i++) begin : g_rom
    assign rom_mem[i] = rom_byte(i, JMP_OP);
  end

  assign rdata = rom_mem[idx];
endmodule

// File: rtl/abus_ram.sv
module abus_ram
  import abus_mem_pkg::*;
#(
  parameter int RAM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [RAM_AW-1:0] idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int RAM_DEPTH = 1 << RAM_AW;

  logic [DATA_W-1:0] ram_mem [RAM_DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < RAM_DEPTH; i++) ram_mem[i] <= '0;
    end else if (we) begin
      ram_mem[idx] <= wdata;
    end
  end

  assign rdata = ram_mem[idx];

  // R3: without a write the addressed byte cannot change
  a_r3_ram_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we ##1 $stable(idx) |-> $stable(rdata));
endmodule

// File: rtl/abus_dbus_arb.sv
module abus_dbus_arb
  import abus_mem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_out,
  input  logic              addr_out,
  input  logic              ext_drive,
  input  logic [DATA_W-1:0] mem_byte,
  input  logic [DATA_W-1:0] addr_byte,
  input  logic [DATA_W-1:0] ext_data,
  output logic [DATA_W-1:0] dbus,
  output logic              dbus_oe,
  output logic              dbus_clash
);
  localparam int N_DRV = 3;
  localparam int CNT_W = $clog2(N_DRV + 1);

  logic [N_DRV-1:0] req;
  logic [CNT_W-1:0] part [N_DRV+1];
  dbus_src_e        src;

  assign req     = {ext_drive, addr_out, mem_out};
  assign part[0] = '0;
  for (genvar i = 0; i < N_DRV; i++) begin : g_cnt
    assign part[i+1] = part[i] + CNT_W'(req[i]);
  end

  always_comb begin
    if (mem_out)        src = SRC_MEM;
    else if (addr_out)  src = SRC_ADDR;
    else if (ext_drive) src = SRC_EXT;
    else                src = SRC_NONE;
  end

  always_comb begin
    case (src)
      SRC_MEM:  dbus = mem_byte;
      SRC_ADDR: dbus = addr_byte;
      SRC_EXT:  dbus = ext_data;
      default:  dbus = '0;
    endcase
    dbus_oe    = (src == SRC_MEM) || (src == SRC_ADDR);
    dbus_clash = part[N_DRV] > CNT_W'(1);
  end

  // R11: the block only drives when one of its own sources is enabled
  a_r11_oe_own: assert property (@(posedge clk) disable iff (!rst_n)
    dbus_oe |-> (mem_out || addr_out));
  // R9: a single requester never raises the clash flag
  a_r9_single_ok: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req) |-> !dbus_clash);
endmodule

// File: rtl/abus_mem_subsys.sv
module abus_mem_subsys
  import abus_mem_pkg::*;
#(
  parameter int RAM_AW = 8,
  parameter int ROM_AW = 4,
  parameter logic [7:0] JMP_OP = 8'h60
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] pc_addr,
  input  logic [15:0] ar_addr,
  input  logic        pc_drive,
  input  logic        ar_drive,
  input  logic        run_mode,
  input  logic [15:0] sw_addr,
  input  logic [7:0]  sw_data,
  input  logic        mem_wr,
  input  logic        mem_out,
  input  logic        addr_out,
  input  logic        hi_sel,
  input  logic        ext_drive,
  input  logic [7:0]  ext_data,
  output logic [7:0]  dbus,
  output logic        dbus_oe,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_data,
  output logic        manual_drive,
  output logic        abus_clash,
  output logic        dbus_clash
);
  logic [ADDR_W-1:0] abus;
  logic              ram_sel;
  logic [DATA_W-1:0] rom_rdata, ram_rdata, addr_byte, wr_byte;
  logic              ram_we;

  abus_addr_path u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .pc_addr    (pc_addr),
    .ar_addr    (ar_addr),
    .pc_drive   (pc_drive),
    .ar_drive   (ar_drive),
    .run_mode   (run_mode),
    .sw_addr    (sw_addr),
    .abus       (abus),
    .mem_addr   (mem_addr),
    .ram_sel    (ram_sel),
    .abus_clash (abus_clash)
  );

  abus_rom #(.ROM_AW(ROM_AW), .JMP_OP(JMP_OP)) u_rom (
    .idx   (mem_addr[ROM_AW-1:0]),
    .rdata (rom_rdata)
  );

  abus_ram #(.RAM_AW(RAM_AW)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ram_we),
    .idx   (mem_addr[RAM_AW-1:0]),
    .wdata (wr_byte),
    .rdata (ram_rdata)
  );

  always_comb begin
    mem_data     = ram_sel ? ram_rdata : rom_rdata;
    addr_byte    = hi_sel ? abus[ADDR_W-1 -: DATA_W] : abus[DATA_W-1:0];
    wr_byte      = run_mode ? dbus : sw_data;
    ram_we       = mem_wr & ram_sel;
    manual_drive = !run_mode & mem_wr & ram_sel;
  end

  abus_dbus_arb u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_out    (mem_out),
    .addr_out   (addr_out),
    .ext_drive  (ext_drive),
    .mem_byte   (mem_data),
    .addr_byte  (addr_byte),
    .ext_data   (ext_data),
    .dbus       (dbus),
    .dbus_oe    (dbus_oe),
    .dbus_clash (dbus_clash)
  );

  // R2: a write into the read-only half leaves the addressed byte as it was
  a_r2_rom_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr && !mem_addr[ADDR_W-1] ##1 $stable(mem_addr) |-> $stable(mem_data));
  // R3: a write into the writable half is visible after the edge
  a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr && mem_addr[ADDR_W-1] ##1 $stable(mem_addr) |-> mem_data == $past(wr_byte));
  // R8: the switch path is released unless a manual write is accepted
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    manual_drive |-> !run_mode && mem_wr && mem_addr[ADDR_W-1]);
  // R6: a memory read puts the addressed byte on the data bus
  a_r6_mem_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
    mem_out |-> dbus == mem_data && dbus_oe);
endmodule

// File: tb/abus_mem_subsys_bench.sv
module abus_mem_subsys_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RAM_AW = 6;
  localparam int ROM_AW = 4;
  localparam logic [7:0] JMP_OP = 8'hC3;
  localparam int RAM_DEPTH = 1 << RAM_AW;

  logic clk = 0, rst_n = 0;
  logic [15:0] pc_addr = 0, ar_addr = 0, sw_addr = 0;
  logic pc_drive = 0, ar_drive = 0, run_mode = 1;
  logic [7:0] sw_data = 0, ext_data = 0;
  logic mem_wr = 0, mem_out = 0, addr_out = 0, hi_sel = 0, ext_drive = 0;
  logic [7:0] dbus, mem_data;
  logic dbus_oe, manual_drive, abus_clash, dbus_clash;
  logic [15:0] mem_addr;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] ram_m [RAM_DEPTH];
  bit pend_wr;
  int pend_idx;
  logic [7:0] pend_val;

  always #(CLK_PERIOD/2) clk = ~clk;

  abus_mem_subsys #(.RAM_AW(RAM_AW), .ROM_AW(ROM_AW), .JMP_OP(JMP_OP)) u_abus_mem_subsys (
    .clk(clk), .rst_n(rst_n), .pc_addr(pc_addr), .ar_addr(ar_addr),
    .pc_drive(pc_drive), .ar_drive(ar_drive), .run_mode(run_mode),
    .sw_addr(sw_addr), .sw_data(sw_data), .mem_wr(mem_wr), .mem_out(mem_out),
    .addr_out(addr_out), .hi_sel(hi_sel), .ext_drive(ext_drive), .ext_data(ext_data),
    .dbus(dbus), .dbus_oe(dbus_oe), .mem_addr(mem_addr), .mem_data(mem_data),
    .manual_drive(manual_drive), .abus_clash(abus_clash), .dbus_clash(dbus_clash)
  );

  function automatic logic [7:0] rom_ref(int i);
    if (i == 0) return JMP_OP;
    if (i == 1) return 8'h00;
    if (i == 2) return 8'h80;
    return 8'((i * 37 + 11) % 256);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Compare every output against the behavioural model, then step one clock.
  task automatic cycle();
    logic [15:0] ab, ad;
    logic [7:0] md, db, ab_byte, wb;
    bit oe;
    int drivers;
    #1;
    ab = pc_drive ? pc_addr : (ar_drive ? ar_addr : 16'h0000);   // R4
    ad = run_mode ? ab : sw_addr;                                 // R5
    if (ad[15]) md = ram_m[ad % RAM_DEPTH];                       // R1
    else        md = rom_ref(ad % (1 << ROM_AW));                 // R10
    ab_byte = hi_sel ? ab[15:8] : ab[7:0];                        // R7
    if (mem_out)        begin db = md;       oe = 1; end          // R6
    else if (addr_out)  begin db = ab_byte;  oe = 1; end
    else if (ext_drive) begin db = ext_data; oe = 0; end          // R11
    else                begin db = 8'h00;    oe = 0; end
    drivers = int'(mem_out) + int'(addr_out) + int'(ext_drive);
    wb = run_mode ? db : sw_data;
    chk("R4/R5 mem_addr", mem_addr, ad);
    chk(ad[15] ? "R1/R3 mem_data ram" : "R1/R10 mem_data rom", mem_data, md);
    chk("R6/R7/R11 dbus", dbus, db);
    chk("R11 dbus_oe", dbus_oe, oe);
    chk("R8 manual_drive", manual_drive, (!run_mode && mem_wr && ad[15]));
    chk("R9 abus_clash", abus_clash, (pc_drive && ar_drive));
    chk("R9 dbus_clash", dbus_clash, (drivers > 1));
    pend_wr  = mem_wr && ad[15];                                  // R2: no model change for rom
    pend_idx = ad % RAM_DEPTH;
    pend_val = wb;
    @(posedge clk);
    if (rst_n && pend_wr) ram_m[pend_idx] = pend_val;
    @(negedge clk);
  endtask

  task automatic idle();
    pc_drive = 0; ar_drive = 0; mem_wr = 0; mem_out = 0; addr_out = 0;
    ext_drive = 0; hi_sel = 0; run_mode = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < RAM_DEPTH; i++) ram_m[i] = 8'hxx;
    @(negedge clk); @(negedge clk);
    // R12: reset clears the writable array
    @(posedge clk); #1;
    for (int i = 0; i < RAM_DEPTH; i++) ram_m[i] = 8'h00;
    @(negedge clk);
    rst_n = 1;
    // reset state: boot word at address 0 (R10)
    cycle();
    ar_drive = 1;
    for (int i = 0; i < RAM_DEPTH; i += 7) begin ar_addr = 16'h8000 + 16'(i); cycle(); end // R12
    idle();
    // R10: boot jump bytes
    pc_drive = 1;
    for (int i = 0; i < 3; i++) begin pc_addr = 16'(i); cycle(); end
    idle();
    // R3: external byte written via address register, then read back
    ar_drive = 1; ar_addr = 16'h8010; ext_drive = 1; ext_data = 8'h5A; mem_wr = 1; cycle();
    mem_wr = 0; ext_drive = 0; mem_out = 1; cycle();
    // R1: mirrored alias of the same location
    ar_addr = 16'h8010 + 16'(RAM_DEPTH); cycle();
    ar_addr = 16'hFFD0; cycle();
    // R2: write to read-only half is dropped
    ar_addr = 16'h0005; ext_drive = 1; ext_data = 8'hFF; mem_out = 0; mem_wr = 1; cycle();
    mem_wr = 0; ext_drive = 0; cycle();
    // R7: address bus bytes
    idle(); pc_drive = 1; pc_addr = 16'hABCD; addr_out = 1; hi_sel = 1; cycle();
    hi_sel = 0; cycle();
    // R4/R9: both drivers, program counter wins
    ar_drive = 1; ar_addr = 16'h8123; cycle();
    mem_out = 1; ext_drive = 1; cycle();
    // R5/R8: manual writes
    idle(); run_mode = 0; sw_addr = 16'h8022; sw_data = 8'h3C; mem_wr = 1; cycle();
    mem_wr = 0; cycle();
    sw_addr = 16'h0001; mem_wr = 1; cycle();
    mem_wr = 0; cycle();
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      pc_drive = ($urandom % 3) == 0;
      ar_drive = ($urandom % 2) == 0;
      run_mode = ($urandom % 5) != 0;
      pc_addr  = 16'($urandom);
      ar_addr  = ($urandom % 2) ? (16'h8000 | 16'($urandom % 256)) : 16'($urandom % 64);
      sw_addr  = 16'($urandom);
      sw_data  = 8'($urandom);
      ext_data = 8'($urandom);
      mem_wr   = ($urandom % 3) == 0;
      mem_out  = ($urandom % 3) == 0;
      addr_out = ($urandom % 4) == 0;
      ext_drive = ($urandom % 3) == 0;
      hi_sel   = $urandom % 2;
      cycle();
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule